// File: doc/BRIEF.md
# Dual-Channel Serial ADC Capture Controller

This block runs a two-channel, simultaneous-sampling serial converter from the logic side. When it receives a start request, it raises the convert line for a fixed number of system clocks, which samples both inputs at once and begins a conversion. It then toggles a divided serial clock 32 times and shifts in the single serial data line. Each half of the frame is split into a channel-0 word and a channel-1 word, and the block presents both words with a one-cycle done strobe. The words are passed through in two's complement, exactly as the converter sends them.

The converter's read-out runs one conversion behind. The pair shifted in after a convert pulse belongs to the previous pulse. The first frame after reset, and the first frame after a wake-up, therefore hold no useful sample, and the block marks them as not good. A small command port selects the low-power states. To enter nap, the block sends two convert pulses with the serial clock frozen low. To enter sleep, it sends a parameterised number of convert pulses (four or more) with the clock frozen. To wake, it sends one serial clock pulse.

Sequencer states: `ST_IDLE` (waiting), `ST_CONV` (convert pulse high), `ST_SHIFT` (32 serial clocks), `ST_DONE` (strobe), `ST_PD_HI` and `ST_PD_LO` (power-down pulse high and low halves), and `ST_WAKE` (one serial clock pulse). The transitions are as follows:
- IDLE→CONV on an accepted start.
- CONV→SHIFT after CONV_HI cycles.
- SHIFT→DONE on the falling serial clock edge after the 32nd sample.
- DONE→IDLE always.
- IDLE→PD_HI on an accepted nap or sleep command.
- PD_HI→PD_LO after CONV_HI cycles.
- PD_LO→PD_HI while pulses remain.
- PD_LO→IDLE after the last pulse.
- IDLE→WAKE on an accepted wake command.
- WAKE→IDLE on the falling edge of its serial clock pulse.

Top module: `adc_pair_capture`

## Requirements
- R1: An accepted start raises `adc_conv_o` for exactly CONV_HI system cycles. The serial clock stays low while the convert line is high.
- R2: Each conversion frame produces exactly 32 rising edges on `adc_sck_o`, with a period of 2*SCK_HALF system cycles. The serial clock and convert line stay low whenever the block is idle.
- R3: Within each 16-bit half-frame, positions FIRST_BIT to FIRST_BIT+RES_W-1 carry the data word MSB first, and the other positions are ignored. The first half goes to `ch0_o` and the second half to `ch1_o`, in two's complement and unchanged.
- R4: `done_o` is high for exactly one cycle, CONV_HI+64*SCK_HALF cycles after the clock edge that accepted the start. `busy_o` is high from the convert pulse until the strobe, and it is low on the strobe cycle.
- R5: The words delivered at a strobe are the samples taken at the previous conversion. On the first strobe after reset or after a wake, `data_ok_o` is 0; on every later strobe it is 1. `data_ok_o` is never high without `done_o`.
- R6: A start request made while `busy_o` is high is ignored. It causes no extra convert pulse and no extra strobe.
- R7: Command code 1 (nap), accepted while awake and idle, sends exactly two convert pulses with the serial clock held low, and then sets `pwr_mode_o` to 1.
- R8: Command code 2 (sleep), accepted while awake and idle, sends exactly SLEEP_PULSES convert pulses with the serial clock held low, and then sets `pwr_mode_o` to 2.
- R9: Command code 3 (wake), accepted in nap or sleep, sends exactly one serial clock pulse with the convert line low, and then sets `pwr_mode_o` to 0.
- R10: While `pwr_mode_o` is not 0, start requests and nap or sleep commands are ignored. While it is 0, a wake command is ignored.
- R11: After reset, `adc_conv_o`, `adc_sck_o`, `busy_o`, `done_o` and `data_ok_o` are 0, and `pwr_mode_o` is 0 (awake).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Request one conversion |
| cmd_valid | input | 1 | Power command present |
| cmd_code | input | 2 | 1 nap, 2 sleep, 3 wake |
| adc_conv_o | output | 1 | Convert-start line to the converter |
| adc_sck_o | output | 1 | Serial clock to the converter |
| adc_sdo_i | input | 1 | Serial data from the converter |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle result strobe |
| data_ok_o | output | 1 | Strobed words hold a real sample |
| ch0_o | output | RES_W | Channel-0 word |
| ch1_o | output | RES_W | Channel-1 word |
| pwr_mode_o | output | 2 | 0 awake, 1 nap, 2 sleep |

## Verification
With default parameters, the strobe is due exactly 130 cycles after the edge that accepts a start. The driver records the cycle of that edge in each queued item, and the monitor samples on the falling clock edge and compares the elapsed cycle count against the figure the requirements give. Convert pulse width and serial clock period are measured on every pulse. The effects of power commands are counted as convert and serial-clock edges over a window that closes only after `busy_o` has fallen.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_SHIFT,
        ST_DONE,
        ST_PD_HI,
        ST_PD_LO,
        ST_WAKE
    } seq_state_t;

    typedef enum logic [1:0] {
        PM_AWAKE = 2'd0,
        PM_NAP   = 2'd1,
        PM_SLEEP = 2'd2
    } pmode_t;

    localparam logic [1:0] CMD_NAP   = 2'd1;
    localparam logic [1:0] CMD_SLEEP = 2'd2;
    localparam logic [1:0] CMD_WAKE  = 2'd3;

    localparam int FRAME_BITS = 32;
    localparam int HALF_BITS  = 16;
    localparam int NAP_PULSES = 2;

endpackage

// File: rtl/adc_sck_gen.sv
module adc_sck_gen #(
    parameter int SCK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic sample,
    output logic fall
);
    localparam int HALF_EFF = (SCK_HALF < 2) ? 2 : SCK_HALF;
    localparam int CW       = $clog2(HALF_EFF);

    logic [CW-1:0] div_cnt;
    logic          sck_r;
    logic          rise_d;
    logic          wrap;

    assign wrap = run && (div_cnt == CW'(HALF_EFF - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            sck_r   <= 1'b0;
            rise_d  <= 1'b0;
        end else begin
            if (!run || wrap) div_cnt <= '0;
            else              div_cnt <= div_cnt + 1'b1;

            if (!run)      sck_r <= 1'b0;
            else if (wrap) sck_r <= ~sck_r;

            rise_d <= wrap && !sck_r;
        end
    end

    assign sck    = sck_r;
    assign sample = rise_d;
    assign fall   = wrap && sck_r;

endmodule

// File: rtl/adc_frame_deser.sv
module adc_frame_deser
    import adc_cap_pkg::*;
#(
    parameter int RES_W     = 14,
    parameter int FIRST_BIT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample,
    input  logic             sdo,
    output logic             full,
    output logic [RES_W-1:0] word0,
    output logic [RES_W-1:0] word1
);
    localparam int BCW  = $clog2(FRAME_BITS + 1);
    localparam int HPOS = $clog2(HALF_BITS);

    logic [BCW-1:0]  bit_cnt;
    logic [HPOS-1:0] pos;
    logic            half;
    logic            in_win;
    logic [RES_W-1:0] sh [2];

    assign pos    = bit_cnt[HPOS-1:0];
    assign half   = bit_cnt[HPOS];
    assign in_win = (int'(pos) >= FIRST_BIT) && (int'(pos) < FIRST_BIT + RES_W);
    assign full   = (bit_cnt == BCW'(FRAME_BITS));

    always_ff @(posedge clk) begin
        if (!rst_n || clear)      bit_cnt <= '0;
        else if (sample && !full) bit_cnt <= bit_cnt + 1'b1;
    end

    for (genvar c = 0; c < 2; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                sh[c] <= '0;
            else if (sample && !full && in_win && (half == 1'(c)))
                sh[c] <= {sh[c][RES_W-2:0], sdo};
        end
    end

    assign word0 = sh[0];
    assign word1 = sh[1];

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_cap_pkg::*;
#(
    parameter int CONV_HI      = 2,
    parameter int SLEEP_PULSES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_code,
    input  logic       frame_end,
    input  logic       sck_fall,
    output logic       conv,
    output logic       sck_run,
    output logic       clr_frame,
    output logic       in_frame,
    output logic       busy,
    output logic       done,
    output logic       data_ok,
    output logic [1:0] pwr_mode
);
    localparam int HI_EFF  = (CONV_HI < 1) ? 1 : CONV_HI;
    localparam int SLP_EFF = (SLEEP_PULSES < 4) ? 4 : SLEEP_PULSES;
    localparam int CNT_W   = $clog2(HI_EFF + 1);
    localparam int PLS_W   = $clog2(SLP_EFF + 1);

    seq_state_t       state, state_nx;
    pmode_t           mode, mode_tgt;
    logic [CNT_W-1:0] cnt;
    logic [PLS_W-1:0] pulse_cnt, pulse_tgt;
    logic             stale, ok_r;
    logic             phase_end, last_pulse;
    logic             acc_start, acc_nap, acc_sleep, acc_wake;

    assign phase_end  = (cnt == CNT_W'(HI_EFF - 1));
    assign last_pulse = (pulse_cnt == pulse_tgt - PLS_W'(1));

    assign acc_start = start_req && (mode == PM_AWAKE);
    assign acc_nap   = cmd_valid && (cmd_code == CMD_NAP)   && (mode == PM_AWAKE);
    assign acc_sleep = cmd_valid && (cmd_code == CMD_SLEEP) && (mode == PM_AWAKE);
    assign acc_wake  = cmd_valid && (cmd_code == CMD_WAKE)  && (mode != PM_AWAKE);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (acc_start)                  state_nx = ST_CONV;
                else if (acc_nap || acc_sleep)  state_nx = ST_PD_HI;
                else if (acc_wake)              state_nx = ST_WAKE;
            end
            ST_CONV:  if (phase_end) state_nx = ST_SHIFT;
            ST_SHIFT: if (frame_end) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            ST_PD_HI: if (phase_end) state_nx = ST_PD_LO;
            ST_PD_LO: begin
                if (phase_end) state_nx = last_pulse ? ST_IDLE : ST_PD_HI;
            end
            ST_WAKE:  if (sck_fall) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register and sequencing registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            mode      <= PM_AWAKE;
            mode_tgt  <= PM_AWAKE;
            cnt       <= '0;
            pulse_cnt <= '0;
            pulse_tgt <= '0;
            stale     <= 1'b1;
            ok_r      <= 1'b0;
        end else begin
            state <= state_nx;

            if (state_nx != state)
                cnt <= '0;
            else if (state == ST_CONV || state == ST_PD_HI || state == ST_PD_LO)
                cnt <= cnt + 1'b1;

            if (state == ST_IDLE && state_nx == ST_PD_HI) begin
                pulse_cnt <= '0;
                pulse_tgt <= acc_nap ? PLS_W'(NAP_PULSES) : PLS_W'(SLP_EFF);
                mode_tgt  <= acc_nap ? PM_NAP : PM_SLEEP;
            end else if (state == ST_PD_LO && state_nx == ST_PD_HI) begin
                pulse_cnt <= pulse_cnt + 1'b1;
            end

            if (state == ST_PD_LO && state_nx == ST_IDLE) mode <= mode_tgt;
            if (state == ST_WAKE && state_nx == ST_IDLE) begin
                mode  <= PM_AWAKE;
                stale <= 1'b1;
            end

            if (state == ST_SHIFT && state_nx == ST_DONE) begin
                ok_r  <= !stale;
                stale <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        conv      = 1'b0;
        sck_run   = 1'b0;
        clr_frame = 1'b0;
        in_frame  = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:  busy = 1'b0;
            ST_CONV: begin
                conv      = 1'b1;
                clr_frame = 1'b1;
            end
            ST_SHIFT: begin
                sck_run  = 1'b1;
                in_frame = 1'b1;
            end
            ST_DONE: begin
                busy = 1'b0;
                done = 1'b1;
            end
            ST_PD_HI: conv = 1'b1;
            ST_PD_LO: conv = 1'b0;
            ST_WAKE:  sck_run = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    assign data_ok  = done && ok_r;
    assign pwr_mode = mode;

endmodule

// File: rtl/adc_pair_capture.sv
module adc_pair_capture
    import adc_cap_pkg::*;
#(
    parameter int RES_W        = 14,
    parameter int SCK_HALF     = 2,
    parameter int CONV_HI      = 2,
    parameter int FIRST_BIT    = 1,
    parameter int SLEEP_PULSES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_code,
    output logic             adc_conv_o,
    output logic             adc_sck_o,
    input  logic             adc_sdo_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             data_ok_o,
    output logic [RES_W-1:0] ch0_o,
    output logic [RES_W-1:0] ch1_o,
    output logic [1:0]       pwr_mode_o
);
    logic sck_run, sck_sample, sck_fall;
    logic clr_frame, in_frame, frame_full, frame_end;
    logic [RES_W-1:0] w0, w1;
    logic [RES_W-1:0] hold0, hold1;

    assign frame_end = in_frame && sck_fall && frame_full;

    adc_seq_ctrl #(
        .CONV_HI      (CONV_HI),
        .SLEEP_PULSES (SLEEP_PULSES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .frame_end (frame_end),
        .sck_fall  (sck_fall),
        .conv      (adc_conv_o),
        .sck_run   (sck_run),
        .clr_frame (clr_frame),
        .in_frame  (in_frame),
        .busy      (busy_o),
        .done      (done_o),
        .data_ok   (data_ok_o),
        .pwr_mode  (pwr_mode_o)
    );

    adc_sck_gen #(
        .SCK_HALF (SCK_HALF)
    ) u_sck (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (sck_run),
        .sck    (adc_sck_o),
        .sample (sck_sample),
        .fall   (sck_fall)
    );

    adc_frame_deser #(
        .RES_W     (RES_W),
        .FIRST_BIT (FIRST_BIT)
    ) u_deser (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clr_frame),
        .sample (sck_sample && in_frame),
        .sdo    (adc_sdo_i),
        .full   (frame_full),
        .word0  (w0),
        .word1  (w1)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold0 <= '0;
            hold1 <= '0;
        end else if (frame_end) begin
            hold0 <= w0;
            hold1 <= w1;
        end
    end

    assign ch0_o = hold0;
    assign ch1_o = hold1;

endmodule

// File: rtl/adc_cap_chk.sv
module adc_cap_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_req,
    input logic       adc_conv_o,
    input logic       adc_sck_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       data_ok_o,
    input logic [1:0] pwr_mode_o
);
    AST_CONV_SCK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(adc_conv_o && adc_sck_o));                                    // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !done_o) |-> (!adc_conv_o && !adc_sck_o));          // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                            // R4

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);                                            // R4

    AST_OK_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        data_ok_o |-> done_o);                                          // R5

    AST_PD_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !done_o && (pwr_mode_o != 2'd0) && start_req) |=> !adc_conv_o); // R10

    AST_MODE_AT_SEQ_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pwr_mode_o) |-> $past(busy_o));                        // R7
endmodule

bind adc_pair_capture adc_cap_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .adc_conv_o (adc_conv_o),
    .adc_sck_o  (adc_sck_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .data_ok_o  (data_ok_o),
    .pwr_mode_o (pwr_mode_o)
);

// File: tb/test_adc_pair_capture.sv
module test_adc_pair_capture;
    localparam int W    = 14;
    localparam int HALF = 2;
    localparam int CHI  = 2;
    localparam int FB   = 1;
    localparam int SLP  = 4;
    localparam int LAT  = CHI + 64 * HALF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_code = 2'd0;
    logic adc_conv_o, adc_sck_o;
    logic adc_sdo_i = 1'b0;
    logic busy_o, done_o, data_ok_o;
    logic [W-1:0] ch0_o, ch1_o;
    logic [1:0] pwr_mode_o;

    always #5 clk = ~clk;

    adc_pair_capture #(
        .RES_W(W), .SCK_HALF(HALF), .CONV_HI(CHI), .FIRST_BIT(FB), .SLEEP_PULSES(SLP)
    ) i_adc_pair_capture (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .adc_conv_o(adc_conv_o), .adc_sck_o(adc_sck_o),
        .adc_sdo_i(adc_sdo_i), .busy_o(busy_o), .done_o(done_o), .data_ok_o(data_ok_o),
        .ch0_o(ch0_o), .ch1_o(ch1_o), .pwr_mode_o(pwr_mode_o)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // converter model: frame holds the pair sampled at the previous pulse
    logic [W-1:0] ana0 = '0, ana1 = '0;
    logic [W-1:0] held0 = 14'h0AAA, held1 = 14'h3555;
    logic [31:0] frame = '1;
    int bit_k = 32;
    int conv_rises = 0;
    int sck_rises = 0;
    time last_rise = 0;

    function automatic logic [31:0] make_frame(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [31:0] f;
        f = '1;
        for (int k = 0; k < 32; k++) begin
            int p;
            p = k % 16;
            if (p >= FB && p < FB + W)
                f[31-k] = (k < 16) ? a[W-1-(p-FB)] : b[W-1-(p-FB)];
        end
        return f;
    endfunction

    always @(posedge adc_conv_o) begin
        conv_rises++;
        frame = make_frame(held0, held1);
        held0 = ana0;
        held1 = ana1;
        bit_k = 0;
    end

    always @(posedge adc_sck_o) begin
        sck_rises++;
        if (bit_k > 0 && bit_k < 32)
            chk("R2 sck period", int'(($time - last_rise) / 10), 2 * HALF);
        last_rise = $time;
        #1;
        if (bit_k < 32) begin
            adc_sdo_i = frame[31-bit_k];
            bit_k++;
        end
    end

    // convert pulse width
    int hi_run = 0;
    always @(negedge clk) begin
        if (adc_conv_o) hi_run++;
        else if (hi_run > 0) begin
            chk("R1 conv width", hi_run, CHI);
            hi_run = 0;
        end
    end

    // scoreboard
    typedef struct {
        logic [W-1:0] e0;
        logic [W-1:0] e1;
        bit ok;
        int t0;
        int s0;
    } exp_t;
    exp_t q[$];

    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (q.size() == 0) chk("R6 unexpected strobe", 1, 0);
            else begin
                exp_t it;
                it = q.pop_front();
                chk("R4 latency", cyc - it.t0, LAT);
                chk("R4 busy low at strobe", int'(busy_o), 0);
                chk("R5 data_ok", int'(data_ok_o), int'(it.ok));
                chk("R2 sck edges per frame", sck_rises - it.s0, 32);
                if (it.ok) begin
                    chk("R3 ch0 word", int'(ch0_o), int'(it.e0));
                    chk("R3 ch1 word", int'(ch1_o), int'(it.e1));
                end
            end
        end
    end

    logic [W-1:0] m0 = '0, m1 = '0;
    bit m_stale = 1'b1;

    task automatic run_conv(input logic [W-1:0] a0, input logic [W-1:0] a1, input bit dup);
        exp_t it;
        int c0;
        ana0 = a0;
        ana1 = a1;
        c0 = conv_rises;
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
        it.e0 = m0; it.e1 = m1; it.ok = !m_stale; it.t0 = cyc; it.s0 = sck_rises;
        q.push_back(it);
        m0 = a0; m1 = a1; m_stale = 1'b0;
        if (dup) begin
            repeat (10) @(negedge clk);
            chk("R4 busy during frame", int'(busy_o), 1);
            start_req = 1'b1;
            @(negedge clk) start_req = 1'b0;
        end
        while (q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
        if (dup) begin
            repeat (200) @(negedge clk);
            chk("R6 single conv pulse", conv_rises - c0, 1);
        end
    endtask

    int dc, ds;
    task automatic do_cmd(input logic [1:0] code);
        int c0, s0;
        c0 = conv_rises;
        s0 = sck_rises;
        @(negedge clk) begin cmd_valid = 1'b1; cmd_code = code; end
        @(negedge clk) begin cmd_valid = 1'b0; cmd_code = 2'd0; end
        for (int i = 0; i < 100 && busy_o; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        dc = conv_rises - c0;
        ds = sck_rises - s0;
    endtask

    task automatic try_start_in_pd();
        int c0;
        c0 = conv_rises;
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
        repeat (60) @(negedge clk);
        chk("R10 start ignored in power-down", conv_rises - c0, 0);
        chk("R10 busy stays low", int'(busy_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R11 conv in reset", int'(adc_conv_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 conv", int'(adc_conv_o), 0);
        chk("R11 sck", int'(adc_sck_o), 0);
        chk("R11 busy", int'(busy_o), 0);
        chk("R11 done", int'(done_o), 0);
        chk("R11 data_ok", int'(data_ok_o), 0);
        chk("R11 mode", int'(pwr_mode_o), 0);

        run_conv(14'h1FFF, 14'h2000, 1'b0);   // R5 first frame stale
        run_conv(14'h0000, 14'h3FFF, 1'b0);   // R3 extremes
        run_conv(14'h1555, 14'h2AAA, 1'b0);
        run_conv(14'h2000, 14'h1FFF, 1'b0);
        run_conv(14'h0123, 14'h3ABC, 1'b1);   // R6

        do_cmd(2'd3);
        chk("R10 wake while awake sck", ds, 0);
        chk("R10 wake while awake mode", int'(pwr_mode_o), 0);

        do_cmd(2'd1);
        chk("R7 nap pulses", dc, 2);
        chk("R7 nap sck static", ds, 0);
        chk("R7 nap mode", int'(pwr_mode_o), 1);

        try_start_in_pd();
        do_cmd(2'd2);
        chk("R10 sleep ignored in nap pulses", dc, 0);
        chk("R10 sleep ignored in nap mode", int'(pwr_mode_o), 1);

        do_cmd(2'd3);
        chk("R9 wake sck pulses", ds, 1);
        chk("R9 wake conv pulses", dc, 0);
        chk("R9 wake mode", int'(pwr_mode_o), 0);
        m_stale = 1'b1;

        run_conv(14'h0F0F, 14'h30F0, 1'b0);   // R5 stale after wake
        run_conv(14'h0001, 14'h3FFE, 1'b0);
        run_conv(14'h2468, 14'h1357, 1'b0);

        do_cmd(2'd2);
        chk("R8 sleep pulses", dc, SLP);
        chk("R8 sleep sck static", ds, 0);
        chk("R8 sleep mode", int'(pwr_mode_o), 2);
        try_start_in_pd();

        do_cmd(2'd3);
        chk("R9 wake from sleep sck", ds, 1);
        chk("R9 wake from sleep mode", int'(pwr_mode_o), 0);
        m_stale = 1'b1;
        run_conv(14'h3000, 14'h0FFF, 1'b0);
        run_conv(14'h1001, 14'h2002, 1'b0);

        chk("R4 no pending strobes", q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule